// File: doc/BRIEF.md
# Branch Broadcast Region Filter

This block holds the configuration that says where a trace unit should broadcast branches. For each retired instruction it reports whether branch broadcasting is active. Up to eight address range comparators sit outside the block. Each one supplies a bit that says whether the current instruction address falls inside its range. The block combines that vector with a programmed selection mask and a single mode bit. In exclude mode, broadcasting is active except inside the selected ranges. In include mode, it is active only inside them.

Software writes and reads the configuration through a 64-bit register port. Writes are accepted only while the trace unit reports that it is idle. A write attempted while the unit is busy is dropped and leaves a sticky error flag set. Mask bits for comparators that are not implemented cannot be set and read back as zero. The decision is registered, so the output lags the comparator vector by one clock.

Top module: `bbcast_region_filter`

## Requirements
- R1: While `rst_n` is low, `rd_data`, `bcast_active` and `wr_err` are all zero, and reset leaves the stored mode and mask at zero.
- R2: Register bits [63:9] always read as zero, and writing ones to them changes nothing.
- R3: Mask bits at positions NUM_PAIRS and above (default NUM_PAIRS = 6, so bits 7 and 6) cannot be set, read as zero, and so never take part in the decision.
- R4: A write with `unit_idle` high stores `wr_data[8]` as the mode bit (0 = exclude, 1 = include) and `wr_data[7:0]` as the selection mask (bit m selects comparator m). These values appear on `rd_data[8]` and `rd_data[7:0]` after the clock edge.
- R5: In exclude mode, the output is 0 when any selected comparator reports a hit and 1 otherwise. An all-zero mask therefore gives 1 for every instruction.
- R6: In include mode, the output is 1 only when at least one selected comparator reports a hit.
- R7: Include mode with an all-zero mask yields 0 for every instruction.
- R8: `bcast_active` is registered. It reflects the `range_hit` vector and the configuration present at the previous rising clock edge.
- R9: A write with `unit_idle` low leaves the register unchanged and sets `wr_err`. `wr_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write value |
| rd_data | output | 64 | Current register contents |
| unit_idle | input | 1 | High when the trace unit is idle |
| range_hit | input | 8 | Per-comparator in-range flags for the current instruction |
| bcast_active | output | 1 | Branch broadcasting active, one cycle after `range_hit` |
| wr_err | output | 1 | Sticky flag for a write attempted while busy |

## Verification
The filter is tried in both modes, with masks that select one comparator, several comparators, all implemented comparators, or none. Each mask is paired with hit vectors that fall inside a selected range, only in unselected ranges, or everywhere. This separates the inversion between exclude and include mode, the treatment of an empty mask in each mode, and the masking of hits from unselected comparators. Masks and writes that touch bits 6, 7 and the reserved bits show whether comparators that are not implemented are really stripped. A hit vector that changes between edges pins down the one-cycle latency. A write attempted while the unit is busy shows that the write is dropped and that the error flag sets and stays set.

// File: rtl/bbcast_region_filter.sv
module bbcast_region_filter #(
  parameter int NUM_PAIRS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  output logic [63:0] rd_data,
  input  logic        unit_idle,
  input  logic [7:0]  range_hit,
  output logic        bcast_active,
  output logic        wr_err
);
  localparam logic [8:0] IMPL9    = (9'd1 << NUM_PAIRS) - 9'd1;
  localparam logic [7:0] IMPL_MSK = IMPL9[7:0];

  logic       mode_q;
  logic [7:0] sel_q;
  logic       bcast_q;
  logic       err_q;
  logic       any_sel_hit;

  assign any_sel_hit  = |(sel_q & range_hit);
  assign rd_data      = {55'd0, mode_q, sel_q};
  assign bcast_active = bcast_q;
  assign wr_err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      sel_q   <= 8'h00;
      bcast_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_en && unit_idle) begin
        mode_q <= wr_data[8];
        sel_q  <= wr_data[7:0] & IMPL_MSK;
      end
      if (wr_en && !unit_idle)
        err_q <= 1'b1;
      bcast_q <= mode_q ? any_sel_hit : !any_sel_hit;
    end
  end

  a_r9_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unit_idle) |=> ($stable(rd_data) && wr_err));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
  a_r4_idle_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unit_idle) |=> (rd_data[8:0] == ($past(wr_data[8:0]) & {1'b1, IMPL_MSK})));
  a_r5_exclude_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[8:0] == 9'h000) |=> bcast_active);
  a_r7_include_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[8:0] == 9'h100) |=> !bcast_active);
  a_r6_include_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[8] && |(rd_data[7:0] & range_hit)) |=> bcast_active);
  a_r5_exclude_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[8] && |(rd_data[7:0] & range_hit)) |=> !bcast_active);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[63:9] == 55'd0);
endmodule

// File: tb/bbcast_region_filter_tb.sv
`timescale 1ns/1ps
module bbcast_region_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        unit_idle = 1'b1;
  logic [7:0]  range_hit = '0;
  logic        bcast_active;
  logic        wr_err;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  bbcast_region_filter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .unit_idle(unit_idle), .range_hit(range_hit),
    .bcast_active(bcast_active), .wr_err(wr_err)
  );

  localparam logic [7:0] IMPL = 8'h3F;
  // {mode, mask, hit, expected}
  localparam logic [17:0] VEC [9] = '{
    {1'b0, 8'h00, 8'hFF, 1'b1},  // R5 empty exclude
    {1'b0, 8'h05, 8'h04, 1'b0},  // R5 selected hit
    {1'b0, 8'h05, 8'h0A, 1'b1},  // R5 unselected hits
    {1'b1, 8'h05, 8'h01, 1'b1},  // R6 selected hit
    {1'b1, 8'h05, 8'h02, 1'b0},  // R6 unselected hit
    {1'b1, 8'h00, 8'hFF, 1'b0},  // R7 empty include
    {1'b1, 8'hC0, 8'hC0, 1'b0},  // R3 unimplemented bits in include
    {1'b0, 8'hC0, 8'hC0, 1'b1},  // R3 unimplemented bits in exclude
    {1'b1, 8'h3F, 8'h20, 1'b1}   // R6 top implemented comparator
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [63:0] d, input logic idle);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; unit_idle = idle;
    @(negedge clk);
    wr_en = 1'b0; unit_idle = 1'b1;
  endtask

  initial begin
    #150000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 64'd0);
    chk("R1 bcast_active", {63'd0, bcast_active}, 64'd0);
    chk("R1 wr_err", {63'd0, wr_err}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      logic md; logic [7:0] mk; logic [7:0] ht; logic ex;
      {md, mk, ht, ex} = VEC[i];
      write_reg({55'h7F_FFFF_FFFF_FFFF, md, mk}, 1'b1);
      chk("R4/R2/R3 readback", rd_data, {55'd0, md, mk & IMPL});
      range_hit = ht;
      @(negedge clk);
      chk("R5/R6/R7 decision", {63'd0, bcast_active}, {63'd0, ex});
    end

    // R8: one-cycle latency
    write_reg({55'd0, 1'b1, 8'h01}, 1'b1);
    range_hit = 8'h00;
    @(negedge clk);
    chk("R8 settle low", {63'd0, bcast_active}, 64'd0);
    range_hit = 8'h01;
    #1;
    chk("R8 no change before edge", {63'd0, bcast_active}, 64'd0);
    @(negedge clk);
    chk("R8 after edge", {63'd0, bcast_active}, 64'd1);

    // R9: busy write dropped, sticky error
    chk("R9 err clear before", {63'd0, wr_err}, 64'd0);
    write_reg({55'd0, 1'b0, 8'h3F}, 1'b0);
    chk("R9 register unchanged", rd_data, {55'd0, 1'b1, 8'h01});
    chk("R9 err set", {63'd0, wr_err}, 64'd1);
    write_reg({55'd0, 1'b0, 8'h02}, 1'b1);
    chk("R9 err sticky", {63'd0, wr_err}, 64'd1);
    chk("R4 idle write after error", rd_data, {55'd0, 1'b0, 8'h02});

    // R1: reset clears error and configuration
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset err", {63'd0, wr_err}, 64'd0);
    chk("R1 reset reg", rd_data, 64'd0);
    rst_n = 1'b1;
    range_hit = 8'hFF;
    @(negedge clk);
    chk("R1/R5 reset config is empty exclude", {63'd0, bcast_active}, 64'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule